// File: doc/BRIEF.md
# Row Activation Rate Limiter

This block tracks row-activate commands for one rank of a banked memory and keeps, for every bank, the earliest cycle at which that bank may next receive an activate. The scheduler presents each activate it issues as a strobe carrying the issue cycle and the target bank. The block then raises the per-bank earliest-activate times. Banks that share a bank group with the target move out by a long spacing. Banks in other groups move out by a short spacing. Once a rolling window holds the maximum number of activates, every bank is also pushed past the end of that window.

The block remembers the last `ACT_CAP` activate cycles, newest first. When an activate arrives while the history is already full and the oldest entry lies less than `T_XAW` cycles before it, the block raises a window-violation flag. It also tracks which banks hold an open row and how many do. An activate to a bank that is still open raises a second error flag. A precharge-complete input closes a bank. The activate input is a valid/ready stream. `act_ready` is high whenever reset is released, so the sender never stalls. An activate is accepted on any rising edge where both signals are high. Precharge-complete is a plain strobe. Configurations with more than one group must set `T_RRD_L` larger than `T_RRD`.

Top module: `rrl_act_limiter`

## Requirements
- R1: On an accepted activate at cycle c to bank b, every other bank whose group equals b's group gets its earliest-activate time raised to at least c + T_RRD_L.
- R2: On the same activate, every bank in a different group gets its earliest-activate time raised to at least c + T_RRD. The activated bank itself receives no spacing term.
- R3: Earliest-activate times only move later. Each new value is the maximum of the old value and all candidate values.
- R4: With N_GRP > 0 the group of a bank is its index modulo N_GRP. With N_GRP = 0 each bank is its own group, so every other bank receives only T_RRD.
- R5: `err_window` is high for the cycle after an accepted activate if, before that activate, the history already held ACT_CAP entries and the new cycle minus the oldest entry is less than T_XAW.
- R6: After an activate is recorded, if the history holds ACT_CAP entries, every bank's earliest-activate time is raised to at least the oldest remaining entry plus T_XAW.
- R7: `err_open` is high for the cycle after an accepted activate whose target bank already had an open row. The activate is still recorded for timing.
- R8: An activate sets its bank's bit in `bank_open`. A precharge-complete for an open bank clears that bit. `active_count` always equals the number of open banks.
- R9: Reset clears all earliest-activate times, open flags, the count and the history. No window violation can be flagged before ACT_CAP activates have been recorded.
- R10: `act_ready` is high whenever reset is released. A precharge-complete for a bank that is not open changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate strobe valid |
| act_ready | output | 1 | Activate accepted when high together with valid |
| act_cycle | input | TW | Issue cycle of the activate |
| act_bank | input | BW | Target bank of the activate |
| pre_done | input | 1 | Precharge of a bank has completed |
| pre_bank | input | BW | Bank whose precharge completed |
| allowed_at | output | N_BANK*TW | Earliest activate cycle per bank, bank k in bits [k*TW +: TW] |
| bank_open | output | N_BANK | One bit per bank, high while a row is open |
| active_count | output | CW | Number of open banks |
| err_window | output | 1 | Activate-window cap exceeded |
| err_open | output | 1 | Activate to a bank with an open row |

## Verification
Every result is registered once. Earliest-activate times, open flags and the count therefore take their new values at the same rising edge that accepts the activate or precharge-complete. The two error flags are high for exactly the following cycle. The bench drives each stimulus for a single cycle from a falling edge and compares all outputs at the next falling edge, which lies after that one updating edge. A model in the bench is updated at the same point. Two instances, one with grouped banks and one with ungrouped banks, receive identical stimulus. Timing gaps are swept from dense to sparse, so that both the spacing terms and the window floor take the maximum.

// File: rtl/rrl_pkg.sv
package rrl_pkg;

  // maximum of three unsigned cycle stamps
  function automatic logic [31:0] max3(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input logic [31:0] c);
    logic [31:0] m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/rrl_group_map.sv
module rrl_group_map #(
  parameter int N_BANK = 8,
  parameter int N_GRP  = 2,
  localparam int BW = (N_BANK > 1) ? $clog2(N_BANK) : 1
) (
  input  logic [BW-1:0]     bank,
  output logic [N_BANK-1:0] same_grp,
  output logic [N_BANK-1:0] self_sel
);

  for (genvar k = 0; k < N_BANK; k++) begin : g_bank
    assign self_sel[k] = (int'(bank) == k);
    if (N_GRP > 0) begin : g_grouped
      assign same_grp[k] = ((k % N_GRP) == (int'(bank) % N_GRP));
    end else begin : g_flat
      assign same_grp[k] = (int'(bank) == k);
    end
  end

endmodule

// File: rtl/rrl_act_history.sv
module rrl_act_history #(
  parameter int TW      = 16,
  parameter int ACT_CAP = 4,
  localparam int HCW = $clog2(ACT_CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_val,
  output logic          full,
  output logic [TW-1:0] oldest,
  output logic          next_full,
  output logic [TW-1:0] next_oldest
);

  logic [TW-1:0]  hist [ACT_CAP];
  logic [HCW-1:0] fill;

  assign full      = (int'(fill) == ACT_CAP);
  assign oldest    = hist[ACT_CAP-1];
  assign next_full = (int'(fill) >= ACT_CAP - 1);

  if (ACT_CAP == 1) begin : g_single
    assign next_oldest = push_val;
  end else begin : g_multi
    assign next_oldest = hist[ACT_CAP-2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < ACT_CAP; i++) hist[i] <= '0;
    end else if (push) begin
      hist[0] <= push_val;
      for (int i = 1; i < ACT_CAP; i++) hist[i] <= hist[i-1];
      if (!full) fill <= fill + 1'b1;
    end
  end

  // once full, the history never empties until reset
  p_full_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);

  // first recorded entry reaches the tail only after ACT_CAP pushes
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= ACT_CAP);

endmodule

// File: rtl/rrl_bank_timer.sv
module rrl_bank_timer #(
  parameter int TW      = 16,
  parameter int T_RRD   = 4,
  parameter int T_RRD_L = 6,
  parameter int T_XAW   = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic          same_grp,
  input  logic          self_sel,
  input  logic [TW-1:0] cyc,
  input  logic          floor_en,
  input  logic [TW-1:0] floor_base,
  output logic [TW-1:0] allowed
);
  import rrl_pkg::*;

  localparam logic [TW-1:0] GAP_S = TW'(T_RRD);
  localparam logic [TW-1:0] GAP_L = TW'(T_RRD_L);
  localparam logic [TW-1:0] GAP_W = TW'(T_XAW);

  logic [TW-1:0] cand_gap, cand_floor, nxt;

  always_comb begin
    cand_gap   = '0;
    cand_floor = '0;
    if (!self_sel) cand_gap = cyc + (same_grp ? GAP_L : GAP_S);
    if (floor_en)  cand_floor = floor_base + GAP_W;
    nxt = TW'(max3(32'(allowed), 32'(cand_gap), 32'(cand_floor)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      allowed <= '0;
    else if (strobe) allowed <= nxt;
  end

  p_group_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && same_grp && !self_sel |=> allowed >= $past(cyc) + GAP_L);

  p_other_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !same_grp && !self_sel |=> allowed >= $past(cyc) + GAP_S);

  p_never_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> allowed >= $past(allowed));

  p_window_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && floor_en |=> allowed >= $past(floor_base) + GAP_W);

endmodule

// File: rtl/rrl_act_limiter.sv
module rrl_act_limiter #(
  parameter int N_BANK  = 8,
  parameter int N_GRP   = 2,
  parameter int TW      = 16,
  parameter int T_RRD   = 4,
  parameter int T_RRD_L = 6,
  parameter int T_XAW   = 20,
  parameter int ACT_CAP = 4,
  localparam int BW = (N_BANK > 1) ? $clog2(N_BANK) : 1,
  localparam int CW = $clog2(N_BANK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 act_valid,
  output logic                 act_ready,
  input  logic [TW-1:0]        act_cycle,
  input  logic [BW-1:0]        act_bank,
  input  logic                 pre_done,
  input  logic [BW-1:0]        pre_bank,
  output logic [N_BANK*TW-1:0] allowed_at,
  output logic [N_BANK-1:0]    bank_open,
  output logic [CW-1:0]        active_count,
  output logic                 err_window,
  output logic                 err_open
);

  localparam logic [TW-1:0] GAP_W = TW'(T_XAW);

  logic              act_fire;
  logic [N_BANK-1:0] same_grp, self_sel;
  logic              h_full, h_next_full;
  logic [TW-1:0]     h_oldest, h_next_oldest;
  logic              pre_hits_target, act_clean, pre_closes;
  logic [N_BANK-1:0] open_nxt;
  logic [CW-1:0]     count_nxt;

  assign act_ready = rst_n;
  assign act_fire  = act_valid && act_ready;

  rrl_group_map #(.N_BANK(N_BANK), .N_GRP(N_GRP)) u_map (
    .bank     (act_bank),
    .same_grp (same_grp),
    .self_sel (self_sel)
  );

  rrl_act_history #(.TW(TW), .ACT_CAP(ACT_CAP)) u_hist (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (act_fire),
    .push_val    (act_cycle),
    .full        (h_full),
    .oldest      (h_oldest),
    .next_full   (h_next_full),
    .next_oldest (h_next_oldest)
  );

  for (genvar k = 0; k < N_BANK; k++) begin : g_timer
    rrl_bank_timer #(
      .TW(TW), .T_RRD(T_RRD), .T_RRD_L(T_RRD_L), .T_XAW(T_XAW)
    ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (act_fire),
      .same_grp   (same_grp[k]),
      .self_sel   (self_sel[k]),
      .cyc        (act_cycle),
      .floor_en   (h_next_full),
      .floor_base (h_next_oldest),
      .allowed    (allowed_at[k*TW +: TW])
    );
  end

  // open-row bookkeeping: a precharge completing in the same cycle
  // closes the bank before the activate looks at it
  always_comb begin
    pre_hits_target = pre_done && (pre_bank == act_bank);
    act_clean       = act_fire && (!bank_open[act_bank] || pre_hits_target);
    pre_closes      = pre_done && bank_open[pre_bank];
    open_nxt        = bank_open;
    if (pre_done) open_nxt[pre_bank] = 1'b0;
    if (act_fire) open_nxt[act_bank] = 1'b1;
    count_nxt = active_count + CW'(act_clean) - CW'(pre_closes);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_open    <= '0;
      active_count <= '0;
      err_window   <= 1'b0;
      err_open     <= 1'b0;
    end else begin
      bank_open    <= open_nxt;
      active_count <= count_nxt;
      err_window   <= act_fire && h_full && ((act_cycle - h_oldest) < GAP_W);
      err_open     <= act_fire && !act_clean;
    end
  end

  p_count_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_count) == $countones(bank_open));

  p_open_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire && !pre_done && bank_open[act_bank] |=> err_open);

  p_open_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> bank_open[$past(act_bank)]);

  p_no_early_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !h_full |=> !err_window);

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_ready);

endmodule

// File: tb/sim_rrl_act_limiter.sv
module sim_rrl_act_limiter;
  localparam int NB = 8, TW = 16, BW = 3, CW = 4;
  localparam int TS = 4, TL = 6, TX = 20, XC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic act_valid = 1'b0, pre_done = 1'b0;
  logic [TW-1:0] act_cycle = '0;
  logic [BW-1:0] act_bank = '0, pre_bank = '0;
  logic rdy0, rdy1, ew0, ew1, eo0, eo1;
  logic [NB*TW-1:0] al0, al1;
  logic [NB-1:0] op0, op1;
  logic [CW-1:0] ac0, ac1;

  int checks = 0, errors = 0, cycles = 0;

  // model state, index 0 = grouped (2 groups), index 1 = ungrouped
  int m_allow [2][NB];
  int m_hist [XC];
  int m_fill;
  bit m_open [NB];
  int m_cnt;
  bit m_ew, m_eo;

  always #2.5 clk = ~clk;

  rrl_act_limiter #(.N_BANK(NB), .N_GRP(2), .TW(TW), .T_RRD(TS),
    .T_RRD_L(TL), .T_XAW(TX), .ACT_CAP(XC)) u0 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(rdy0),
    .act_cycle(act_cycle), .act_bank(act_bank), .pre_done(pre_done),
    .pre_bank(pre_bank), .allowed_at(al0), .bank_open(op0),
    .active_count(ac0), .err_window(ew0), .err_open(eo0));

  rrl_act_limiter #(.N_BANK(NB), .N_GRP(0), .TW(TW), .T_RRD(TS),
    .T_RRD_L(TL), .T_XAW(TX), .ACT_CAP(XC)) u1 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ready(rdy1),
    .act_cycle(act_cycle), .act_bank(act_bank), .pre_done(pre_done),
    .pre_bank(pre_bank), .allowed_at(al1), .bank_open(op1),
    .active_count(ac1), .err_window(ew1), .err_open(eo1));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    for (int k = 0; k < NB; k++) begin
      chk("R1 R2 R3 R6 grouped allowed", int'(al0[k*TW +: TW]), m_allow[0][k]);
      chk("R4 ungrouped allowed", int'(al1[k*TW +: TW]), m_allow[1][k]);
      chk("R8 open flag", int'(op0[k]), int'(m_open[k]));
      chk("R8 open flag ungrouped", int'(op1[k]), int'(m_open[k]));
    end
    chk("R8 active count", int'(ac0), m_cnt);
    chk("R8 active count ungrouped", int'(ac1), m_cnt);
    chk("R5 window error", int'(ew0), int'(m_ew));
    chk("R5 window error ungrouped", int'(ew1), int'(m_ew));
    chk("R7 open error", int'(eo0), int'(m_eo));
    chk("R7 open error ungrouped", int'(eo1), int'(m_eo));
    chk("R10 ready", int'(rdy0 & rdy1), 1);
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic model_act(input int b, input int c);
    int fl;
    m_ew = (m_fill == XC) && (c - m_hist[XC-1] < TX);
    for (int i = XC - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = c;
    if (m_fill < XC) m_fill++;
    fl = (m_fill == XC) ? m_hist[XC-1] + TX : 0;
    for (int k = 0; k < NB; k++) begin
      int g0, g1;
      g0 = (k == b) ? 0 : (((k % 2) == (b % 2)) ? c + TL : c + TS);
      g1 = (k == b) ? 0 : c + TS;
      m_allow[0][k] = mx(m_allow[0][k], mx(g0, fl));
      m_allow[1][k] = mx(m_allow[1][k], mx(g1, fl));
    end
    m_eo = m_open[b];
    if (!m_open[b]) m_cnt++;
    m_open[b] = 1'b1;
  endtask

  task automatic do_act(input int b, input int c);
    @(negedge clk);
    act_valid = 1'b1; act_bank = BW'(b); act_cycle = TW'(c);
    @(negedge clk);
    act_valid = 1'b0;
    model_act(b, c);
    check_all();
  endtask

  task automatic do_pre(input int b);
    @(negedge clk);
    pre_done = 1'b1; pre_bank = BW'(b);
    @(negedge clk);
    pre_done = 1'b0;
    m_ew = 1'b0; m_eo = 1'b0;
    if (m_open[b]) begin m_open[b] = 1'b0; m_cnt--; end
    check_all();
  endtask

  initial begin
    int t;
    for (int k = 0; k < NB; k++) begin
      m_allow[0][k] = 0; m_allow[1][k] = 0; m_open[k] = 1'b0;
    end
    for (int i = 0; i < XC; i++) m_hist[i] = 0;
    m_fill = 0; m_cnt = 0; m_ew = 0; m_eo = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();  // R9 reset state

    // dense burst over all banks: window fills, R5 and R6 engage
    t = 10;
    for (int b = 0; b < NB; b++) begin
      do_act(b, t);
      t += 2;
    end
    for (int b = 0; b < NB; b++) do_pre(b);
    do_pre(3);  // R10 precharge of closed bank changes nothing

    // gap sweep from dense to sparse, all banks
    for (int step = 1; step <= 12; step++) begin
      for (int b = 0; b < NB; b++) begin
        do_act((b * 3 + step) % NB, t);
        do_pre((b * 3 + step) % NB);
        t += step;
      end
    end

    // R7 activate an open bank twice
    t += 30;
    do_act(5, t);
    t += 7;
    do_act(5, t);
    do_pre(5);

    // R3 small candidates after a large floor leave times unchanged
    t += 40;
    do_act(1, t); do_act(2, t + 1); do_act(3, t + 2); do_act(4, t + 3);
    do_act(6, t + 4);
    for (int b = 0; b < NB; b++) do_pre(b);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule